// File: doc/BRIEF.md
# Pixel Range Clamp with Depth Expansion

This stage sits in a display output pipe and handles one pixel of three 12-bit components per clock. A component may carry a narrower value, 8 or 10 bits, held in its upper bits. When expansion is switched on, the block fills the vacant low bits with copies of the component's own top bits. Without expansion, such a value would leave those bits at zero. A limited-range clamp can then hold each component between the black and white levels of a chosen depth. Every result appears on the output registers exactly one clock after the input.

The expansion settings act on the pixel sampled at the same edge. The clamp setting is different: it goes into an applied-setting register. A clamp that is already active is never switched straight to another setting. It is first returned to "disabled, format 0" for one cycle, and only then does the new setting take over. Hardware can therefore rely on the same clear-then-set order that a programming sequence would follow.

Top module: `pxl_range_stage`

## Requirements
- R1: While reset is asserted and after its release, outValid is 0, outR, outG and outB are 0, and the applied clamp setting is disabled with format 0.
- R2: outValid equals the value inValid had at the previous rising edge. A pixel sampled with inValid high appears on outR/outG/outB after that same edge.
- R3: While inValid is low, the three pixel outputs keep their values.
- R4: With cfgExpEn low, each component passes through expansion unchanged, including its low bits.
- R5: With cfgExpEn high and cfgExpMode = 0 (10-bit input), x = in[11:2] and the output is {x, x[9:8]}. Input bits [1:0] are ignored.
- R6: With cfgExpEn high and cfgExpMode = 1 (8-bit input), x = in[11:4] and the output is {x, x[7:4]}. Input bits [3:0] are ignored.
- R7: The clamp is active when the applied setting has enable = 1 and a format code of 1 (8 bpc), 2 (10 bpc) or 3 (12 bpc). Each component is then limited to 256..3760. At 12-bit alignment these bounds are the same for all three codes: 16..235 at 8 bpc, 64..940 at 10 bpc and 256..3760 at 12 bpc.
- R8: Format code 0 means no range limiting. Codes 4 to 6 and code 7 (reserved for programmable bounds) also pass the pixel through. A cleared enable passes the pixel through whatever the code.
- R9: Expansion is applied before the clamp. For example, an 8-bit 0xEC expands to 0xECE and is clamped to 0xEB0, and an 8-bit 0x0F expands to 0x0F0 and is raised to 0x100.
- R10: The requested clamp setting {cfgClampEn, cfgClampFmt} is taken into the applied register at a clock edge. If the request differs from the applied setting and the applied setting is not {0, 0}, the register first goes to {0, 0} for one cycle, and the new setting is loaded at the next edge. Each pixel uses the setting that was applied before its sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input pixel strobe |
| inR | input | 12 | Red / Cr component in |
| inG | input | 12 | Green / Y component in |
| inB | input | 12 | Blue / Cb component in |
| cfgExpEn | input | 1 | Enables depth expansion |
| cfgExpMode | input | 1 | Expansion source depth: 0 = 10-bit, 1 = 8-bit |
| cfgClampEn | input | 1 | Requested clamp enable |
| cfgClampFmt | input | 3 | Requested clamp format code |
| outValid | output | 1 | Output pixel strobe |
| outR | output | 12 | Red / Cr component out |
| outG | output | 12 | Green / Y component out |
| outB | output | 12 | Blue / Cb component out |

## Verification
The applied clamp setting is the only hidden state. If it were wrong, the clamp would limit pixels when it should not, or fail to limit them, and this would show at the outputs on the first valid pixel sampled after the bad setting. The reference model therefore tracks the clear-then-set order itself. The bench switches settings while pixels stream at 0xFFF, so the single unclamped pixel in the middle shows up in exactly one output cycle. Expansion faults show on the next output beat, in the low bits, whenever the input's top bits are not all equal.

// File: rtl/pxl_range_pkg.sv
package pxl_range_pkg;

  localparam int PIX_W = 12;
  localparam int CFG_W = 4;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_D8   = 3'd1,
    FMT_D10  = 3'd2,
    FMT_D12  = 3'd3,
    FMT_PROG = 3'd7
  } clampFmt_e;

  typedef struct packed {
    logic             expOn;
    logic             expNarrow;
    logic             clampOn;
    logic [PIX_W-1:0] loBound;
    logic [PIX_W-1:0] hiBound;
  } dpCtrl_t;

  // Black level of a depth (6 + 2*code bits), aligned to PIX_W bits.
  function automatic logic [PIX_W-1:0] limLo(input logic [2:0] code);
    int depth;
    depth = 6 + 2 * int'(code);
    return PIX_W'((16 << (depth - 8)) << (PIX_W - depth));
  endfunction

  // White level of a depth, aligned to PIX_W bits.
  function automatic logic [PIX_W-1:0] limHi(input logic [2:0] code);
    int depth;
    depth = 6 + 2 * int'(code);
    return PIX_W'((235 << (depth - 8)) << (PIX_W - depth));
  endfunction

endpackage

// File: rtl/pxl_range_ctrl.sv
module pxl_range_ctrl
  import pxl_range_pkg::*;
#(
  parameter int W = PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgExpEn,
  input  logic             cfgExpMode,
  input  logic             cfgClampEn,
  input  logic [2:0]       cfgClampFmt,
  output dpCtrl_t          strobe,
  output logic [CFG_W-1:0] appliedCfg
);

  localparam logic [CFG_W-1:0] CLEARED = '0;

  logic [CFG_W-1:0] reqCfg;
  logic [CFG_W-1:0] appQ;
  logic [2:0]       appFmt;
  logic             fmtLimits;

  assign reqCfg = {cfgClampEn, cfgClampFmt};

  // Clear-then-set: an active setting never moves straight to another one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      appQ <= CLEARED;
    end else if (reqCfg != appQ) begin
      appQ <= (appQ == CLEARED) ? reqCfg : CLEARED;
    end
  end

  assign appFmt = appQ[2:0];

  always_comb begin
    unique case (appFmt)
      FMT_D8, FMT_D10, FMT_D12: fmtLimits = 1'b1;
      default:                  fmtLimits = 1'b0;
    endcase
  end

  always_comb begin
    strobe.expOn     = cfgExpEn;
    strobe.expNarrow = cfgExpMode;
    strobe.clampOn   = appQ[3] & fmtLimits;
    strobe.loBound   = fmtLimits ? limLo(appFmt) : '0;
    strobe.hiBound   = fmtLimits ? limHi(appFmt) : '1;
  end

  assign appliedCfg = appQ;

endmodule

// File: rtl/pxl_range_dp.sv
module pxl_range_dp
  import pxl_range_pkg::*;
#(
  parameter int W  = PIX_W,
  parameter int NC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic [NC*W-1:0] inPix,
  input  dpCtrl_t       strobe,
  output logic          outValid,
  output logic [NC*W-1:0] outPix
);

  localparam int TEN_DROP   = 2;
  localparam int EIGHT_DROP = 4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  for (genvar ch = 0; ch < NC; ch++) begin : g_chan
    logic [W-1:0]            rawV;
    logic [W-TEN_DROP-1:0]   tenV;
    logic [W-EIGHT_DROP-1:0] eightV;
    logic [W-1:0]            expV;
    logic [W-1:0]            limV;
    logic [W-1:0]            pixQ;

    assign rawV   = inPix[ch*W +: W];
    assign tenV   = rawV[W-1:TEN_DROP];
    assign eightV = rawV[W-1:EIGHT_DROP];

    // Fill vacated low bits from the component's own top bits.
    always_comb begin
      if (!strobe.expOn)         expV = rawV;
      else if (strobe.expNarrow) expV = {eightV, eightV[W-EIGHT_DROP-1 -: EIGHT_DROP]};
      else                       expV = {tenV, tenV[W-TEN_DROP-1 -: TEN_DROP]};
    end

    always_comb begin
      if (!strobe.clampOn)              limV = expV;
      else if (expV < strobe.loBound)   limV = strobe.loBound;
      else if (expV > strobe.hiBound)   limV = strobe.hiBound;
      else                              limV = expV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pixQ <= '0;
      else if (inValid) pixQ <= limV;
    end

    assign outPix[ch*W +: W] = pixQ;
  end

endmodule

// File: rtl/pxl_range_stage.sv
module pxl_range_stage
  import pxl_range_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inR,
  input  logic [PIX_W-1:0] inG,
  input  logic [PIX_W-1:0] inB,
  input  logic             cfgExpEn,
  input  logic             cfgExpMode,
  input  logic             cfgClampEn,
  input  logic [2:0]       cfgClampFmt,
  output logic             outValid,
  output logic [PIX_W-1:0] outR,
  output logic [PIX_W-1:0] outG,
  output logic [PIX_W-1:0] outB
);

  dpCtrl_t            strobe;
  logic [CFG_W-1:0]   appliedCfg;
  logic [3*PIX_W-1:0] pixOut;

  pxl_range_ctrl #(.W(PIX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgExpEn    (cfgExpEn),
    .cfgExpMode  (cfgExpMode),
    .cfgClampEn  (cfgClampEn),
    .cfgClampFmt (cfgClampFmt),
    .strobe      (strobe),
    .appliedCfg  (appliedCfg)
  );

  pxl_range_dp #(.W(PIX_W), .NC(3)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inPix    ({inR, inG, inB}),
    .strobe   (strobe),
    .outValid (outValid),
    .outPix   (pixOut)
  );

  assign {outR, outG, outB} = pixOut;

endmodule

// File: rtl/pxl_range_chk.sv
module pxl_range_chk
  import pxl_range_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             outValid,
  input logic [PIX_W-1:0] outR,
  input logic [PIX_W-1:0] outG,
  input logic [PIX_W-1:0] outB,
  input logic             cfgExpEn,
  input logic             cfgExpMode,
  input logic             clampOn,
  input logic [CFG_W-1:0] appliedCfg
);

  localparam logic [PIX_W-1:0] LIM_LO = limLo(3'd3);
  localparam logic [PIX_W-1:0] LIM_HI = limHi(3'd3);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R3
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable({outR, outG, outB}));

  // R7
  clamp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && clampOn) |=> (outR >= LIM_LO && outR <= LIM_HI &&
                              outG >= LIM_LO && outG <= LIM_HI &&
                              outB >= LIM_LO && outB <= LIM_HI));

  // R10
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (appliedCfg != '0) |=> (appliedCfg == $past(appliedCfg) || appliedCfg == '0));

  // R6
  eight_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && cfgExpEn && cfgExpMode && !clampOn) |=>
      (outR[3:0] == outR[11:8] && outG[3:0] == outG[11:8] && outB[3:0] == outB[11:8]));

endmodule

bind pxl_range_stage pxl_range_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .outValid   (outValid),
  .outR       (outR),
  .outG       (outG),
  .outB       (outB),
  .cfgExpEn   (cfgExpEn),
  .cfgExpMode (cfgExpMode),
  .clampOn    (strobe.clampOn),
  .appliedCfg (appliedCfg)
);

// File: tb/pxl_range_stage_tb.sv
module pxl_range_stage_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inR = '0, inG = '0, inB = '0;
  logic        cfgExpEn = 1'b0, cfgExpMode = 1'b0, cfgClampEn = 1'b0;
  logic [2:0]  cfgClampFmt = '0;
  logic        outValid;
  logic [11:0] outR, outG, outB;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  pxl_range_stage u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .inR(inR), .inG(inG), .inB(inB),
    .cfgExpEn(cfgExpEn), .cfgExpMode(cfgExpMode),
    .cfgClampEn(cfgClampEn), .cfgClampFmt(cfgClampFmt),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  // ---------------- behavioural reference ----------------
  int mValid = 0, mR = 0, mG = 0, mB = 0;
  int appEn = 0, appFmt = 0;

  function automatic int expandM(int v, bit en, bit mode);
    int x;
    if (!en) return v;
    if (mode) begin x = v / 16; return x * 16 + x / 16; end
    x = v / 4;
    return x * 4 + x / 256;
  endfunction

  function automatic int clampM(int v, int en, int fmt);
    if (en != 1 || fmt < 1 || fmt > 3) return v;
    if (v < 256) return 256;
    if (v > 3760) return 3760;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mValid = 0; mR = 0; mG = 0; mB = 0; appEn = 0; appFmt = 0;
    end else begin
      mValid = inValid;
      if (inValid) begin
        mR = clampM(expandM(int'(inR), cfgExpEn, cfgExpMode), appEn, appFmt);
        mG = clampM(expandM(int'(inG), cfgExpEn, cfgExpMode), appEn, appFmt);
        mB = clampM(expandM(int'(inB), cfgExpEn, cfgExpMode), appEn, appFmt);
      end
      if (int'(cfgClampEn) != appEn || int'(cfgClampFmt) != appFmt) begin
        if (appEn == 0 && appFmt == 0) begin
          appEn = int'(cfgClampEn); appFmt = int'(cfgClampFmt);
        end else begin
          appEn = 0; appFmt = 0;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({phase, " model valid"}, int'(outValid), mValid);
      chk({phase, " model R"}, int'(outR), mR);
      chk({phase, " model G"}, int'(outG), mG);
      chk({phase, " model B"}, int'(outB), mB);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit v, int r, int g, int b);
    @(negedge clk);
    inValid = v; inR = 12'(r); inG = 12'(g); inB = 12'(b);
  endtask

  task automatic pixCheck(string req, int r, int g, int b, int er, int eg, int eb);
    drive(1, r, g, b);
    @(negedge clk);
    inValid = 0;
    chk(req, int'(outR), er);
    chk(req, int'(outG), eg);
    chk(req, int'(outB), eb);
  endtask

  task automatic setClamp(bit en, int fmt);
    @(negedge clk);
    inValid = 0; cfgClampEn = en; cfgClampFmt = 3'(fmt);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(outValid), 0);
    chk("R1 R", int'(outR), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(outB), 0);

    phase = "R4";
    drive(1, 12'h123, 12'hABC, 12'hFFF);
    @(negedge clk);
    chk("R2 valid high", int'(outValid), 1);
    chk("R4 R", int'(outR), 12'h123);
    chk("R4 G", int'(outG), 12'hABC);
    chk("R4 B", int'(outB), 12'hFFF);
    inValid = 0; inR = 12'h777;
    @(negedge clk);
    chk("R2 valid low", int'(outValid), 0);
    chk("R3 hold R", int'(outR), 12'h123);

    phase = "R5";
    cfgExpEn = 1; cfgExpMode = 0;
    pixCheck("R5 ten-bit fill", 12'h801, 12'h400, 12'hC00, 12'h802, 12'h401, 12'hC03);

    phase = "R6";
    cfgExpMode = 1;
    pixCheck("R6 eight-bit fill", 12'hA5F, 12'h30C, 12'hFF0, 12'hA5A, 12'h303, 12'hFFF);

    phase = "R7";
    cfgExpEn = 0;
    setClamp(1, 1);
    pixCheck("R7 code1", 12'h050, 12'hFFF, 12'h800, 12'h100, 12'hEB0, 12'h800);

    phase = "R9";
    cfgExpEn = 1; cfgExpMode = 1;
    pixCheck("R9 expand then clamp", 12'hEC0, 12'h0F0, 12'h800, 12'hEB0, 12'h100, 12'h808);
    cfgExpEn = 0;

    // R10: active {1,1} -> {1,3}: old, cleared, new
    phase = "R10";
    @(negedge clk);
    cfgClampFmt = 3'd3; inValid = 1; inR = 12'hFFF; inG = 12'h000; inB = 12'h100;
    @(negedge clk);
    chk("R10 old setting", int'(outR), 12'hEB0);
    @(negedge clk);
    chk("R10 cleared cycle", int'(outR), 12'hFFF);
    chk("R10 cleared cycle G", int'(outG), 0);
    @(negedge clk);
    chk("R10 new setting", int'(outR), 12'hEB0);
    chk("R7 code3 low", int'(outG), 12'h100);
    inValid = 0;

    phase = "R8";
    setClamp(1, 7);
    pixCheck("R8 code7", 12'hFFF, 12'h000, 12'h010, 12'hFFF, 12'h000, 12'h010);
    setClamp(1, 0);
    pixCheck("R8 code0", 12'hFFF, 12'h001, 12'hEB1, 12'hFFF, 12'h001, 12'hEB1);
    setClamp(0, 2);
    pixCheck("R8 enable low", 12'hFFF, 12'h000, 12'h800, 12'hFFF, 12'h000, 12'h800);

    // R10: from cleared {0,0} straight to {1,2}
    setClamp(0, 0);
    phase = "R10";
    @(negedge clk);
    cfgClampEn = 1; cfgClampFmt = 3'd2; inValid = 1; inR = 12'hFFF;
    @(negedge clk);
    chk("R10 from cleared first", int'(outR), 12'hFFF);
    @(negedge clk);
    chk("R10 from cleared applied", int'(outR), 12'hEB0);
    inValid = 0;

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      inValid = ($urandom_range(0, 3) != 0);
      inR = 12'($urandom); inG = 12'($urandom); inB = 12'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        cfgExpEn = 1'($urandom); cfgExpMode = 1'($urandom);
      end
      if ($urandom_range(0, 9) == 0) begin
        cfgClampEn = 1'($urandom); cfgClampFmt = 3'($urandom);
      end
    end
    @(negedge clk);
    inValid = 0;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule